// File: doc/BRIEF.md
# Shoot-Through Boost Inverter PWM Modulator

This block generates the five gate commands for a single-phase full bridge fed through a switched-boost network with one extra boost switch. A counter produces a symmetric up-down triangle (the bridge carrier). A second triangle, folded from the same counter, runs at exactly twice that rate, so it stays phase-locked to the first. The signed sine sample and its negation are compared with the bridge carrier to drive the two bridge legs. Two thresholds are compared with the fast carrier. One sets the boost-switch on-time in the carrier valleys. The other sets a shoot-through interval at the carrier peaks. During shoot-through every bridge gate is forced on.

A controller supplies a fresh sine sample and thresholds at any time. The block takes them, together with the carrier half-period, only when the bridge carrier sits at zero, so a switching period is never split between two settings. Setting the boost threshold to about three times the shoot-through width gives the three-state sequence used for low input-current ripple. The sequence is boost on, then both off, then shoot-through with the boost switch off. For a shoot-through duty d and half-period P, the thresholds are roughly P·(1−d) and 3·P·d.

Top module: `stboost_pwm`

## Requirements
- R1: While reset is asserted, all five gate outputs are low and the phase output reads zero. The gates stay low until the first clock edge after reset is released.
- R2: The phase output counts up by one per clock from 0 to the latched half-period P, then down by one per clock to 0. One bridge carrier period is therefore 2P clocks.
- R3: The half-period is sampled only when the phase is 0. An odd value is rounded down to even, and a value below 2 is replaced by 2.
- R4: Outside shoot-through, the leg A upper gate is high exactly when the latched signed sine sample is greater than the signed value 2·phase − P, and the leg A lower gate is its complement.
- R5: Outside shoot-through, the leg B upper gate is high exactly when the negated sine sample is greater than 2·phase − P, and the leg B lower gate is its complement.
- R6: The fast carrier equals 2·min(phase, P − phase). It has a valley at every bridge-carrier valley and peak, so shoot-through and boost pulses each occur twice per bridge period.
- R7: Shoot-through is active when the fast carrier is greater than the latched shoot-through threshold. While it is active, all four bridge gates are high.
- R8: The boost gate is high when the fast carrier is less than the latched boost threshold.
- R9: The boost gate is never high during shoot-through. A boost threshold larger than the shoot-through threshold is latched as the shoot-through threshold.
- R10: The sine sample and both thresholds are latched only when the phase is 0. A change at any other time has no effect on any gate until the next valley.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | REF_W | Signed sine reference sample |
| period_in | input | CNT_W | Carrier half-period P in clocks |
| boost_thr_in | input | CNT_W | Boost-switch threshold on the fast carrier |
| st_thr_in | input | CNT_W | Shoot-through threshold on the fast carrier |
| gate_a_hi | output | 1 | Leg A upper switch gate |
| gate_a_lo | output | 1 | Leg A lower switch gate |
| gate_b_hi | output | 1 | Leg B upper switch gate |
| gate_b_lo | output | 1 | Leg B lower switch gate |
| gate_boost | output | 1 | Extra boost switch gate |
| phase_o | output | CNT_W | Bridge carrier count |

## Verification
The bench targets several boundary cases:
- Odd half-periods, zero and one. A design that skipped the rounding or the floor would show a wrong peak phase, or would stall at zero.
- A boost threshold above the shoot-through threshold. Without the clamp, the boost switch would conduct into a shorted bridge.
- Sine changes in the middle of a period. A design that did not hold its shadows would switch a leg mid-period.
- Sine values beyond the carrier range, which pin a leg.

Pulse counts over an aligned window confirm that both fast-carrier events repeat twice per bridge period and not once.

// File: rtl/stboost_pkg.sv
package stboost_pkg;
   localparam int unsigned MIN_PERIOD = 2;
   localparam int unsigned NUM_LEGS   = 2;
   typedef enum logic {LEG_A = 1'b0, LEG_B = 1'b1} leg_e;
endpackage

// File: rtl/stboost_carrier.sv
module stboost_carrier
   import stboost_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] period_in,
   output logic [CNT_W-1:0] phase_o,
   output logic [CNT_W-1:0] per_o,
   output logic [CNT_W-1:0] car2_o,
   output logic             valley_o
);
   logic [CNT_W-1:0] cnt_q, per_q, per_even, per_fold, half, fold;
   logic             down_q;

   // round requested half-period to even, floor at the minimum
   always_comb begin
      per_even = {period_in[CNT_W-1:1], 1'b0};
      per_fold = (per_even < CNT_W'(MIN_PERIOD)) ? CNT_W'(MIN_PERIOD) : per_even;
   end

   assign valley_o = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         per_q  <= '0;
         down_q <= 1'b0;
      end else if (valley_o) begin
         per_q  <= per_fold;
         cnt_q  <= CNT_W'(1);
         down_q <= 1'b0;
      end else if (!down_q) begin
         cnt_q  <= cnt_q + CNT_W'(1);
         down_q <= ((cnt_q + CNT_W'(1)) == per_q);
      end else begin
         cnt_q  <= cnt_q - CNT_W'(1);
      end
   end

   // fast carrier folded from the slow count: twice the rate, locked phase
   always_comb begin
      half = per_q >> 1;
      fold = (cnt_q <= half) ? cnt_q : (per_q - cnt_q);
   end

   assign car2_o  = {fold[CNT_W-2:0], 1'b0};
   assign phase_o = cnt_q;
   assign per_o   = per_q;

   p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !valley_o |-> (cnt_q <= per_q));
   p_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q == $past(cnt_q) - CNT_W'(1))));
   p_period_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      valley_o |=> ((per_q[0] == 1'b0) && (per_q >= CNT_W'(MIN_PERIOD))));
endmodule

// File: rtl/stboost_shadow.sv
module stboost_shadow #(
   parameter int CNT_W = 10,
   parameter int REF_W = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load_i,
   input  logic signed [REF_W-1:0] ref_in,
   input  logic [CNT_W-1:0]        boost_thr_in,
   input  logic [CNT_W-1:0]        st_thr_in,
   output logic signed [REF_W-1:0] ref_o,
   output logic [CNT_W-1:0]        v5_o,
   output logic [CNT_W-1:0]        vst_o
);
   logic [CNT_W-1:0] v5_clamped;

   // boost window may not reach into the shoot-through window
   assign v5_clamped = (boost_thr_in > st_thr_in) ? st_thr_in : boost_thr_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_o <= '0;
         v5_o  <= '0;
         vst_o <= '0;
      end else if (load_i) begin
         ref_o <= ref_in;
         v5_o  <= v5_clamped;
         vst_o <= st_thr_in;
      end
   end

   p_hold_midperiod_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> ($stable(ref_o) && $stable(v5_o) && $stable(vst_o)));
   p_thr_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
      v5_o <= vst_o);
endmodule

// File: rtl/stboost_bridge.sv
module stboost_bridge
   import stboost_pkg::*;
#(
   parameter int CNT_W = 10,
   parameter int REF_W = 12
) (
   input  logic [CNT_W-1:0]        phase_i,
   input  logic [CNT_W-1:0]        per_i,
   input  logic signed [REF_W-1:0] ref_i,
   output logic [NUM_LEGS-1:0]     leg_hi_o
);
   localparam int CW = ((REF_W > CNT_W + 1) ? REF_W : CNT_W + 1) + 2;

   logic signed [CW-1:0] car_bip, ref_x;

   // bipolar carrier -P..+P centred on zero
   always_comb begin
      car_bip = CW'({phase_i, 1'b0}) - CW'(per_i);
      ref_x   = CW'(ref_i);
   end

   for (genvar i = 0; i < NUM_LEGS; i++) begin : g_leg
      logic signed [CW-1:0] leg_ref;
      if (i == int'(LEG_B)) begin : g_neg
         assign leg_ref = -ref_x;
      end else begin : g_pos
         assign leg_ref = ref_x;
      end
      assign leg_hi_o[i] = (leg_ref > car_bip);
   end
endmodule

// File: rtl/stboost_boostst.sv
module stboost_boostst #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] car2_i,
   input  logic [CNT_W-1:0] v5_i,
   input  logic [CNT_W-1:0] vst_i,
   output logic             st_o,
   output logic             boost_o
);
   // shoot-through from the peaks, boost from the valleys
   assign st_o    = (car2_i > vst_i);
   assign boost_o = (car2_i < v5_i);

   p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(st_o && boost_o));
endmodule

// File: rtl/stboost_pwm.sv
module stboost_pwm
   import stboost_pkg::*;
#(
   parameter int CNT_W = 10,
   parameter int REF_W = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [REF_W-1:0] ref_in,
   input  logic [CNT_W-1:0]        period_in,
   input  logic [CNT_W-1:0]        boost_thr_in,
   input  logic [CNT_W-1:0]        st_thr_in,
   output logic                    gate_a_hi,
   output logic                    gate_a_lo,
   output logic                    gate_b_hi,
   output logic                    gate_b_lo,
   output logic                    gate_boost,
   output logic [CNT_W-1:0]        phase_o
);
   if (CNT_W < 3) begin : g_bad_cnt
      $error("stboost_pwm: CNT_W must be at least 3");
   end
   if (REF_W < 2) begin : g_bad_ref
      $error("stboost_pwm: REF_W must be at least 2");
   end

   logic [CNT_W-1:0]        per, car2, v5, vst;
   logic                    valley, st, boost, active_q;
   logic signed [REF_W-1:0] ref_l;
   logic [NUM_LEGS-1:0]     leg_hi;

   stboost_carrier #(.CNT_W(CNT_W)) u_car (
      .clk(clk), .rst_n(rst_n), .period_in(period_in),
      .phase_o(phase_o), .per_o(per), .car2_o(car2), .valley_o(valley));

   stboost_shadow #(.CNT_W(CNT_W), .REF_W(REF_W)) u_shd (
      .clk(clk), .rst_n(rst_n), .load_i(valley), .ref_in(ref_in),
      .boost_thr_in(boost_thr_in), .st_thr_in(st_thr_in),
      .ref_o(ref_l), .v5_o(v5), .vst_o(vst));

   stboost_bridge #(.CNT_W(CNT_W), .REF_W(REF_W)) u_brg (
      .phase_i(phase_o), .per_i(per), .ref_i(ref_l), .leg_hi_o(leg_hi));

   stboost_boostst #(.CNT_W(CNT_W)) u_bst (
      .clk(clk), .rst_n(rst_n), .car2_i(car2), .v5_i(v5), .vst_i(vst),
      .st_o(st), .boost_o(boost));

   // gates released only once the first settings have been latched
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= 1'b0;
      else        active_q <= 1'b1;
   end

   assign gate_a_hi  = active_q & ( leg_hi[LEG_A] | st);
   assign gate_a_lo  = active_q & (~leg_hi[LEG_A] | st);
   assign gate_b_hi  = active_q & ( leg_hi[LEG_B] | st);
   assign gate_b_lo  = active_q & (~leg_hi[LEG_B] | st);
   assign gate_boost = active_q & boost;

   p_leg_complement_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !st) |-> ((gate_a_hi != gate_a_lo) && (gate_b_hi != gate_b_lo)));
   p_st_all_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && st) |-> (gate_a_hi && gate_a_lo && gate_b_hi && gate_b_lo && !gate_boost));
endmodule

// File: tb/stboost_pwm_test.sv
`timescale 1ns/1ps
module stboost_pwm_test;
   localparam int CNT_W = 10;
   localparam int REF_W = 12;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic signed [REF_W-1:0] ref_in = '0;
   logic [CNT_W-1:0]        period_in = '0;
   logic [CNT_W-1:0]        boost_thr_in = '0;
   logic [CNT_W-1:0]        st_thr_in = '0;
   logic gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo, gate_boost;
   logic [CNT_W-1:0] phase_o;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   // behavioural reference state
   int m_cnt = 0, m_p = 0, m_ref = 0, m_v5 = 0, m_vst = 0;
   bit m_dn = 1'b0, m_act = 1'b0;

   always #2 clk = ~clk;

   stboost_pwm #(.CNT_W(CNT_W), .REF_W(REF_W)) uut (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .period_in(period_in),
      .boost_thr_in(boost_thr_in), .st_thr_in(st_thr_in),
      .gate_a_hi(gate_a_hi), .gate_a_lo(gate_a_lo), .gate_b_hi(gate_b_hi),
      .gate_b_lo(gate_b_lo), .gate_boost(gate_boost), .phase_o(phase_o));

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_p = 0; m_ref = 0; m_v5 = 0; m_vst = 0; m_dn = 0; m_act = 0;
      end else begin
         m_act = 1'b1;
         if (m_cnt == 0) begin
            m_p = (int'(period_in) / 2) * 2;
            if (m_p < 2) m_p = 2;
            m_ref = int'($signed(ref_in));
            m_vst = int'(st_thr_in);
            m_v5  = (int'(boost_thr_in) > m_vst) ? m_vst : int'(boost_thr_in);
            m_cnt = 1; m_dn = 1'b0;
         end else if (!m_dn) begin
            m_cnt = m_cnt + 1;
            if (m_cnt == m_p) m_dn = 1'b1;
         end else begin
            m_cnt = m_cnt - 1;
         end
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the reference, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         int fast, bip;
         bit ahi, bhi, st, bo;
         fast = 2 * ((m_cnt <= m_p / 2) ? m_cnt : m_p - m_cnt);   // R6
         bip  = 2 * m_cnt - m_p;
         ahi  = (m_ref > bip);
         bhi  = (-m_ref > bip);
         st   = (fast > m_vst);
         bo   = (fast < m_v5) && !st;
         if (!rst_n) begin
            check("R1 phase in reset", int'(phase_o), 0);
            check("R1 gates in reset",
                  int'({gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo, gate_boost}), 0);
         end else begin
            check("R2/R3 phase", int'(phase_o), m_cnt);
            check("R4/R7/R10 leg A upper", int'(gate_a_hi), m_act ? int'(ahi | st) : 0);
            check("R4/R7/R10 leg A lower", int'(gate_a_lo), m_act ? int'(!ahi | st) : 0);
            check("R5/R7/R10 leg B upper", int'(gate_b_hi), m_act ? int'(bhi | st) : 0);
            check("R5/R7/R10 leg B lower", int'(gate_b_lo), m_act ? int'(!bhi | st) : 0);
            check("R8/R9 boost", int'(gate_boost), m_act ? int'(bo) : 0);
         end
      end
   end

   task automatic setup(input int r, input int p, input int v5, input int vst);
      @(negedge clk);
      ref_in = REF_W'(r); period_in = CNT_W'(p);
      boost_thr_in = CNT_W'(v5); st_thr_in = CNT_W'(vst);
   endtask

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic peak_phase(input int n, output int pk);
      pk = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (int'(phase_o) > pk) pk = int'(phase_o);
      end
   endtask

   initial begin
      int pk, st_rise, bo_rise;
      bit st_prev, bo_prev, st_now;
      setup(30, 100, 30, 90);
      run(5);                                // R1 reset hold
      rst_n = 1'b1;
      run(600);                              // R2 R4 R5 R6 R7 R8 base pattern
      setup(-70, 100, 30, 90);               // R10 mid-period change
      run(450);
      setup(120, 100, 20, 80);               // leg A pinned beyond range
      run(450);
      setup(-100, 100, 95, 60);              // R9 boost threshold clamped
      run(450);
      setup(0, 100, 0, 0);                   // R7 shoot-through wide, no boost
      run(450);
      // R6: two shoot-through and two boost events per bridge period
      setup(25, 100, 30, 90);
      run(420);
      while (phase_o != '0) @(negedge clk);
      st_rise = 0; bo_rise = 0; st_prev = 0; bo_prev = 0;
      for (int i = 0; i < 400; i++) begin
         st_now = gate_a_hi & gate_a_lo & gate_b_hi & gate_b_lo;
         if (st_now && !st_prev) st_rise++;
         if (gate_boost && !bo_prev) bo_rise++;
         st_prev = st_now; bo_prev = gate_boost;
         @(negedge clk);
      end
      check("R6 shoot-through pulses in two bridge periods", st_rise, 4);
      check("R6 boost pulses in two bridge periods", bo_rise, 5);
      // R3 period folding
      setup(10, 21, 4, 16);
      run(210);
      peak_phase(60, pk);
      check("R3 odd half-period rounds down", pk, 20);
      setup(0, 1, 0, 2);
      run(50);
      peak_phase(20, pk);
      check("R3 half-period one floors to two", pk, 2);
      setup(0, 0, 0, 2);
      run(10);
      peak_phase(20, pk);
      check("R3 half-period zero floors to two", pk, 2);
      setup(-3, 6, 2, 4);
      run(60);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         done = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule